// File: doc/BRIEF.md
# S/PDIF Receive Sample Word Formatter

This block sits between an S/PDIF bi-phase decoder and a receive data FIFO. The decoder hands over one decoded subframe at a time: a 4-bit preamble code, a 24-bit audio field whose low nibble is the auxiliary data, and the validity, user, channel-status and parity bits. The block turns each subframe into one 32-bit word in the layout picked by a two-bit width mode. In 16-bit mode a pack option instead merges a left/right pair into a single word. A start-channel input decides which channel a capture begins on, so that software always reads words in a known channel order.

The subframe input cannot be stalled, because the decoder produces subframes at the line rate. It is therefore a valid-only stream. The FIFO side is a valid/ready write port. A word is offered for exactly one cycle: `wr_valid` is high in the same cycle as the subframe that completes it. If `wr_ready` is low in that cycle, the word is lost and a sticky overrun flag is raised. The flag stays set until a clear pulse arrives. Changing any configuration input resynchronises the channel alignment.

Top module: `spdif_rx_word_fmt`

## Requirements
- R1: During and right after reset, `wr_valid` and `overrun` are 0, no capture alignment is held and no packed half is pending.
- R2: Preamble codes are 4'h1 (block start, left), 4'h2 (left) and 4'h4 (right); every other code is invalid. In unpacked modes, subframes are discarded until one from the start channel arrives (`start_left`=1: a left code, 0: the right code). From that subframe on, every subframe, including one with an invalid code, yields a word.
- R3: Mode 2'b00/2'b01/2'b10 gives 16/20/24-bit samples, right-justified from bit 0 with zeros up to bit 23. The samples are audio[23:8], audio[23:4] and audio[23:0].
- R4: Mode 2'b11 (raw) gives bits 31:28 = {P,C,U,V}, bits 27:8 = audio[23:4], bits 7:4 = audio[3:0] and bits 3:0 = preamble code.
- R5: In modes 2'b00 to 2'b10, when the word is not packed, bits 31:28 = {P,C,U,V} (P at bit 31) and bits 27:24 = the preamble code.
- R6: A packed word holds the right sample audio[23:8] in bits 31:16 and the left sample audio[23:8] in bits 15:0.
- R7: In packed mode, a pair opens only on a start-channel subframe and closes on the next subframe from the other channel, which produces the word. A subframe that is neither of these (same channel again or an invalid code) discards the pending half. A start-channel subframe in that position opens a new pair.
- R8: `pack_en` has no effect unless the mode is 2'b00.
- R9: `wr_valid` is high only in a cycle with `sf_valid` high and a completed word. If `wr_ready` is low in that cycle, the word is dropped and `overrun` is 1 from the next cycle.
- R10: `overrun` stays set until a cycle with `ovr_clr` high clears it. A drop in the same cycle as a clear leaves it set.
- R11: A change of `mode`, `pack_en` or `start_left` clears the alignment and any pending half. The subframe in the cycle of the change is judged as the first one of a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Width mode: 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| pack_en | input | 1 | Pair packing, used only in 16-bit mode |
| start_left | input | 1 | Capture start channel: 1 left, 0 right |
| sf_valid | input | 1 | Subframe present this cycle |
| sf_pre | input | 4 | Preamble code of the subframe |
| sf_audio | input | 24 | Audio field; bits 3:0 are the aux nibble |
| sf_v | input | 1 | Validity bit |
| sf_u | input | 1 | User data bit |
| sf_c | input | 1 | Channel status bit |
| sf_p | input | 1 | Parity bit |
| wr_valid | output | 1 | Word offered to the FIFO this cycle |
| wr_ready | input | 1 | FIFO can take a word |
| wr_data | output | 32 | Formatted word |
| ovr_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky flag: a word was dropped |

## Verification
The hardest cases to reach from the ports are the coincidences. One is a dropped word in the same cycle as an overrun clear. Another is a configuration change while a packed half is pending, or a second same-channel subframe arriving before its pair closes. Directed sequences place each of these exactly: same-channel repeats, invalid codes between halves, and a configuration switch mid-pair. A long random phase then mixes preamble codes, idle cycles, ready gaps and clear pulses against a behavioural model, which is compared on every clock.

// File: rtl/spdif_fmt_pkg.sv
package spdif_fmt_pkg;
  localparam int AUD_W  = 24;
  localparam int PRE_W  = 4;
  localparam int FLAG_W = 4;
  localparam int WORD_W = FLAG_W + PRE_W + AUD_W;
  localparam int HALF_W = WORD_W / 2;
  localparam int CFG_W  = 4;

  typedef enum logic [1:0] {
    WM_16  = 2'b00,
    WM_20  = 2'b01,
    WM_24  = 2'b10,
    WM_RAW = 2'b11
  } width_mode_e;

  localparam logic [PRE_W-1:0] PRE_BLK   = 4'h1;
  localparam logic [PRE_W-1:0] PRE_LEFT  = 4'h2;
  localparam logic [PRE_W-1:0] PRE_RIGHT = 4'h4;
endpackage

// File: rtl/spdif_fmt_align.sv
module spdif_fmt_align
  import spdif_fmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sf_valid,
  input  logic [PRE_W-1:0]     sf_pre,
  input  logic [1:0]           mode,
  input  logic                 pack_en,
  input  logic                 start_left,
  input  logic [HALF_W-1:0]    half_in,
  output logic                 emit,
  output logic                 packed_sel,
  output logic [WORD_W-1:0]    pair_word
);
  logic [CFG_W-1:0]  cfg_now, cfg_q;
  logic              cfg_chg;
  logic              aligned_q, aligned_d, aligned_eff;
  logic              pend_q, pend_d, pend_eff;
  logic [HALF_W-1:0] half_q, half_d;
  logic              is_left, is_right, on_start, on_other;

  assign cfg_now     = {mode, pack_en, start_left};
  assign cfg_chg     = (cfg_now != cfg_q);
  assign aligned_eff = aligned_q && !cfg_chg;
  assign pend_eff    = pend_q && !cfg_chg;
  assign packed_sel  = pack_en && (mode == WM_16);

  assign is_left  = (sf_pre == PRE_BLK) || (sf_pre == PRE_LEFT);
  assign is_right = (sf_pre == PRE_RIGHT);
  assign on_start = start_left ? is_left : is_right;
  assign on_other = start_left ? is_right : is_left;

  always_comb begin
    emit      = 1'b0;
    aligned_d = aligned_eff;
    pend_d    = pend_eff;
    half_d    = half_q;
    if (sf_valid) begin
      if (packed_sel) begin
        if (pend_eff && on_other) begin
          emit   = 1'b1;
          pend_d = 1'b0;
        end else if (on_start) begin
          pend_d = 1'b1;
          half_d = half_in;
        end else begin
          pend_d = 1'b0;
        end
      end else if (aligned_eff || on_start) begin
        emit      = 1'b1;
        aligned_d = 1'b1;
      end
    end
  end

  // right half always lands in the upper lane
  assign pair_word = start_left ? {half_in, half_q} : {half_q, half_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      aligned_q <= 1'b0;
      pend_q    <= 1'b0;
      half_q    <= '0;
    end else begin
      cfg_q     <= cfg_now;
      aligned_q <= aligned_d;
      pend_q    <= pend_d;
      half_q    <= half_d;
    end
  end
endmodule

// File: rtl/spdif_fmt_layout.sv
module spdif_fmt_layout
  import spdif_fmt_pkg::*;
(
  input  logic [1:0]        mode,
  input  logic              packed_sel,
  input  logic [WORD_W-1:0] pair_word,
  input  logic [AUD_W-1:0]  audio,
  input  logic [PRE_W-1:0]  pre,
  input  logic [FLAG_W-1:0] flags,
  output logic [WORD_W-1:0] word
);
  localparam int N_WIDTHS = 3;
  logic [AUD_W-1:0] just [N_WIDTHS];

  for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
    localparam int KW = 16 + 4 * g;
    assign just[g] = AUD_W'(audio[AUD_W-1 -: KW]);
  end

  always_comb begin
    if (packed_sel)
      word = pair_word;
    else if (mode == WM_RAW)
      word = {flags, audio, pre};
    else
      word = {flags, pre, just[mode]};
  end
endmodule

// File: rtl/spdif_fmt_ovr.sv
module spdif_fmt_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic clr,
  output logic sticky
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sticky <= 1'b0;
    else if (drop) sticky <= 1'b1;
    else if (clr)  sticky <= 1'b0;
  end
endmodule

// File: rtl/spdif_rx_word_fmt.sv
module spdif_rx_word_fmt
  import spdif_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              pack_en,
  input  logic              start_left,
  input  logic              sf_valid,
  input  logic [PRE_W-1:0]  sf_pre,
  input  logic [AUD_W-1:0]  sf_audio,
  input  logic              sf_v,
  input  logic              sf_u,
  input  logic              sf_c,
  input  logic              sf_p,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  input  logic              ovr_clr,
  output logic              overrun
);
  logic              emit, packed_sel;
  logic [WORD_W-1:0] pair_word;

  spdif_fmt_align u_align (
    .clk        (clk),
    .rst_n      (rst_n),
    .sf_valid   (sf_valid),
    .sf_pre     (sf_pre),
    .mode       (mode),
    .pack_en    (pack_en),
    .start_left (start_left),
    .half_in    (sf_audio[AUD_W-1 -: HALF_W]),
    .emit       (emit),
    .packed_sel (packed_sel),
    .pair_word  (pair_word)
  );

  spdif_fmt_layout u_layout (
    .mode       (mode),
    .packed_sel (packed_sel),
    .pair_word  (pair_word),
    .audio      (sf_audio),
    .pre        (sf_pre),
    .flags      ({sf_p, sf_c, sf_u, sf_v}),
    .word       (wr_data)
  );

  spdif_fmt_ovr u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .drop   (emit && !wr_ready),
    .clr    (ovr_clr),
    .sticky (overrun)
  );

  assign wr_valid = emit;
endmodule

// File: rtl/spdif_rx_word_fmt_chk.sv
module spdif_rx_word_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic        pack_en,
  input logic        start_left,
  input logic        sf_valid,
  input logic [3:0]  sf_pre,
  input logic [23:0] sf_audio,
  input logic        sf_v,
  input logic        sf_u,
  input logic        sf_c,
  input logic        sf_p,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_data,
  input logic        ovr_clr,
  input logic        overrun
);
  // R9
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> overrun);

  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  // R10
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !(wr_valid && !wr_ready) |=> !overrun);

  // R9
  no_word_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sf_valid |-> !wr_valid);

  // R5
  status_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && mode != 2'b11 && !(pack_en && mode == 2'b00)
    |-> wr_data[31:24] == {sf_p, sf_c, sf_u, sf_v, sf_pre});

  // R4
  raw_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && mode == 2'b11
    |-> wr_data == {sf_p, sf_c, sf_u, sf_v, sf_audio, sf_pre});

  // R6
  packed_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && pack_en && mode == 2'b00
    |-> (start_left ? wr_data[31:16] : wr_data[15:0]) == sf_audio[23:8]);
endmodule

bind spdif_rx_word_fmt spdif_rx_word_fmt_chk u_chk (.*);

// File: tb/test_spdif_rx_word_fmt.sv
`timescale 1ns/1ps
module test_spdif_rx_word_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b10;
  logic        pack_en = 1'b0;
  logic        start_left = 1'b1;
  logic        sf_valid = 1'b0;
  logic [3:0]  sf_pre = 4'h0;
  logic [23:0] sf_audio = '0;
  logic        sf_v = 0, sf_u = 0, sf_c = 0, sf_p = 0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_data;
  logic        ovr_clr = 1'b0;
  logic        overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // model state
  bit          m_al, m_pend, m_ovr;
  logic [15:0] m_half;
  logic [3:0]  m_cfg;

  always #2.5 clk = ~clk;

  spdif_rx_word_fmt i_spdif_rx_word_fmt (.*);

  function automatic bit left_code(input logic [3:0] p);
    return p == 4'h1 || p == 4'h2;
  endfunction

  task automatic report(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_al = 0; m_pend = 0; m_ovr = 0; m_half = '0; m_cfg = '0;
    end else if (!done) begin
      bit chg, al, pend, pk, st, ot, ev;
      logic [31:0] ew;
      logic [3:0]  fl;
      chg  = {mode, pack_en, start_left} != m_cfg;
      al   = m_al && !chg;
      pend = m_pend && !chg;
      pk   = pack_en && mode == 2'b00;
      st   = start_left ? left_code(sf_pre) : (sf_pre == 4'h4);
      ot   = start_left ? (sf_pre == 4'h4) : left_code(sf_pre);
      fl   = {sf_p, sf_c, sf_u, sf_v};
      ev   = 0;
      ew   = '0;
      if (sf_valid) begin
        if (pk) begin
          if (pend && ot) begin
            ev = 1; pend = 0;
            ew = start_left ? {sf_audio[23:8], m_half} : {m_half, sf_audio[23:8]};
          end else if (st) begin
            pend = 1; m_half = sf_audio[23:8];
          end else pend = 0;
        end else if (al || st) begin
          ev = 1; al = 1;
          case (mode)
            2'b00: ew = {fl, sf_pre, 8'h00, sf_audio[23:8]};
            2'b01: ew = {fl, sf_pre, 4'h0, sf_audio[23:4]};
            2'b10: ew = {fl, sf_pre, sf_audio};
            default: ew = {fl, sf_audio, sf_pre};
          endcase
        end
      end
      report("overrun", {31'b0, overrun}, {31'b0, m_ovr});
      report("wr_valid", {31'b0, wr_valid}, {31'b0, ev});
      if (ev && wr_valid) report("wr_data", wr_data, ew);
      if (ev && !wr_ready) m_ovr = 1;
      else if (ovr_clr) m_ovr = 0;
      m_al = al; m_pend = pend; m_cfg = {mode, pack_en, start_left};
    end
  end

  task automatic put(input logic [3:0] pre, input logic rdy = 1'b1, input logic clr = 1'b0);
    logic [31:0] r;
    @(posedge clk); #1;
    r = $urandom;
    sf_valid = 1'b1; sf_pre = pre; sf_audio = r[23:0];
    {sf_p, sf_c, sf_u, sf_v} = r[31:28];
    wr_ready = rdy; ovr_clr = clr;
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sf_valid = 1'b0; wr_ready = 1'b1; ovr_clr = 1'b0;
    end
  endtask

  task automatic cfg(input logic [1:0] m, input logic pk, input logic sl);
    @(posedge clk); #1;
    sf_valid = 1'b0; mode = m; pack_en = pk; start_left = sl;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    report("reset wr_valid", {31'b0, wr_valid}, 32'd0);
    report("reset overrun", {31'b0, overrun}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    gap(2);

    // R2 alignment, start on left
    tag = "R2";
    put(4'h4); put(4'h8); put(4'h2); put(4'h4); put(4'h8); put(4'h1); put(4'h4);
    gap(2);
    // R2 start on right
    cfg(2'b10, 1'b0, 1'b0);
    put(4'h2); put(4'h1); put(4'h4); put(4'h2); gap(1);

    // R3 R5 widths
    tag = "R3";
    cfg(2'b00, 1'b0, 1'b1); put(4'h1); put(4'h4); put(4'h2); put(4'h4);
    cfg(2'b01, 1'b0, 1'b1); put(4'h2); put(4'h4); put(4'h0); put(4'h4);
    tag = "R5";
    cfg(2'b10, 1'b0, 1'b1); put(4'h1); put(4'h4); put(4'hF); put(4'h2);
    // R4 raw
    tag = "R4";
    cfg(2'b11, 1'b0, 1'b1); put(4'h2); put(4'h4); put(4'h7); put(4'h1); gap(1);

    // R6 R7 packed, left first
    tag = "R6";
    cfg(2'b00, 1'b1, 1'b1); put(4'h4); put(4'h2); put(4'h4); put(4'h1); put(4'h4);
    tag = "R7";
    put(4'h2); put(4'h2); put(4'h4); put(4'h2); put(4'h8); put(4'h4); put(4'h1); gap(2); put(4'h4);
    // packed, right first
    cfg(2'b00, 1'b1, 1'b0); put(4'h2); put(4'h4); put(4'h2); put(4'h4); put(4'h4); put(4'h1);

    // R8 pack ignored outside 16-bit
    tag = "R8";
    cfg(2'b01, 1'b1, 1'b1); put(4'h2); put(4'h4); put(4'h2);
    cfg(2'b11, 1'b1, 1'b1); put(4'h1); put(4'h4);

    // R9 R10 overrun
    tag = "R9";
    cfg(2'b10, 1'b0, 1'b1); put(4'h2); put(4'h4, 1'b0); gap(3);
    tag = "R10";
    put(4'h2, 1'b1, 1'b1); gap(2);
    put(4'h4, 1'b0, 1'b1); gap(2);
    put(4'h2, 1'b1, 1'b1); gap(1);

    // R11 config change mid-pair and mid-stream
    tag = "R11";
    cfg(2'b00, 1'b1, 1'b1); put(4'h2);
    @(posedge clk); #1 start_left = 1'b0; sf_valid = 1'b1; sf_pre = 4'h4;
    put(4'h2);
    cfg(2'b10, 1'b0, 1'b0); put(4'h2); put(4'h4); put(4'h2);
    @(posedge clk); #1 mode = 2'b01; sf_pre = 4'h2;
    put(4'h4); put(4'h2);
    gap(2);

    // random mix
    tag = "R7/R10 random";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[7:0] == 0) cfg(r[9:8], r[10], r[11]);
      else if (r[14:12] == 0) gap(1);
      else begin
        logic [3:0] p;
        case (r[17:16])
          2'd0: p = 4'h1;
          2'd1: p = 4'h2;
          2'd2: p = 4'h4;
          default: p = r[21:18];
        endcase
        put(p, r[25:22] != 0, r[29:26] == 0);
      end
    end
    gap(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule